// File: doc/BRIEF.md
# Double-Buffered PWM Timer

A 16-bit up-counting timer that generates a pulse-width-modulated waveform from two compare values. The second compare value sets the length of the period: when the counter reaches it, the period ends, the counter reloads to 0xFFFC and the output takes a programmed "period" level. The first compare value sets the pulse edge: when the counter reaches it, the output takes a programmed "edge" level. Since each period starts at 0xFFFC, a compare value of N gives N + 5 timer ticks, so software obtains a time t by loading t × f / prescale − 5 (or t × f − 5 when an external clock drives the count).

Software reaches the timer through a byte-wide register port: a control byte, a status byte, two 16-bit compare registers split into high and low bytes, and a read-only view of the counter. New compare values go into buffers and reach the active comparators only at the end of the running period, so the output never shows a partly updated pulse. The tick comes from the system clock divided by 2, 4 or 8, or from rising edges of an external clock that is resynchronised into the system domain. Each period end sets a capture flag that can raise an interrupt request.

Top module: `pwm_timer`

## Requirements
- R1: With PWM mode on (control bit 0), a tick on which the counter equals the edge compare drives the output to the edge level (control bit 2); a tick on which it equals the period compare drives it to the period level (control bit 3), and this wins when both match. With PWM mode off the output is 0.
- R2: A period-compare match in PWM mode, and the cycle PWM mode is switched on, reload the counter to 0xFFFC; a period is (period compare + 5) ticks and the segment at the period level is (edge compare + 5) ticks.
- R3: In PWM mode, compare values written during a period are used only from the next period on; with PWM mode off the comparators follow the buffers at once.
- R4: When the edge level equals the period level, the output settles at that level and keeps it.
- R5: A period end sets status bit 0; writing a 1 to a status bit clears it, and a set in the same cycle wins. The interrupt request is high when (status bit 0 and control bit 6) or (status bit 1 or 2, and control bit 7) hold and the mask input is low.
- R6: Outside PWM mode a match on the edge or period compare sets status bit 1 or 2; in PWM mode these two bits are never set.
- R7: Writing a compare high byte disables that comparator until its low byte is written.
- R8: Control bits 5:4 select the tick: 00 system clock / 2, 01 / 4, 10 / 8, 11 one tick per rising edge of the external clock input after a two-stage synchroniser.
- R9: With PWM mode and one-pulse mode (control bit 1) both set, the timer behaves exactly as in PWM mode.
- R10: After reset the counter holds 0xFFFC, the control and status bytes are 0, the output and interrupt request are 0, and both compare buffers and comparators hold 0xFFFF.
- R11: Register addresses: 0 control, 1 status, 2/3 edge compare high/low, 4/5 period compare high/low, 6/7 counter high/low (read only); reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| extClkIn | input | 1 | External count clock, asynchronous |
| irqMask | input | 1 | Global interrupt mask, high blocks the request |
| irq | output | 1 | Interrupt request |
| pwmOut | output | 1 | PWM waveform |

## Verification
The period-end event and a software write to the status byte can land in the same cycle. The bench holds a stream of clear-capture-flag writes across a whole period boundary and counts the cycles in which the interrupt request is high: the set must win for exactly one cycle before the next clear removes it. The same collision between a compare-buffer write and the buffer-to-comparator transfer is covered by writing a new edge value mid-period and checking, segment by segment, that the change appears only in the following period.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int TMR_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int NCMP    = 2;
  localparam int NFLAG   = 3;
  localparam int DIV_W   = 3;
  localparam int SYNC_N  = 2;
  localparam logic [TMR_W-1:0] RELOAD_VAL = {TMR_W{1'b1}} - TMR_W'(3);

  // control byte bit positions
  localparam int CB_PWM   = 0;
  localparam int CB_OPM   = 1;
  localparam int CB_LVL1  = 2;
  localparam int CB_LVL2  = 3;
  localparam int CB_CLK   = 4;
  localparam int CB_CAPIE = 6;
  localparam int CB_CMPIE = 7;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd6;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd7;

  typedef enum logic [1:0] {
    CLK_DIV2 = 2'b00,
    CLK_DIV4 = 2'b01,
    CLK_DIV8 = 2'b10,
    CLK_EXT  = 2'b11
  } clkSel_e;

  typedef struct packed {
    logic                       pwmMode;
    logic                       lvl1;
    logic                       lvl2;
    clkSel_e                    clkSel;
    logic [NCMP-1:0][TMR_W-1:0] cmpBuf;
    logic [NCMP-1:0]            cmpHold;
  } ctlStrobe_t;

  typedef struct packed {
    logic            periodEnd;
    logic [NCMP-1:0] cmpMatch;
  } evt_t;
endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              irqMask,
  input  evt_t              evt,
  input  logic [TMR_W-1:0]  cntVal,
  output ctlStrobe_t        ctl,
  output logic [BYTE_W-1:0] rdData,
  output logic [NFLAG-1:0]  flagsQ,
  output logic              irq
);
  logic [BYTE_W-1:0]          ctrlQ;
  logic [NCMP-1:0][TMR_W-1:0] bufQ;
  logic [NCMP-1:0]            holdQ;
  logic [NFLAG-1:0]           setVec;
  logic [NFLAG-1:0]           clrVec;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (wrEn && addr == A_CTRL) ctrlQ <= wrData;
  end

  // compare buffers: high byte write holds the comparator, low byte releases it
  for (genvar g = 0; g < NCMP; g++) begin : g_cmpBuf
    localparam logic [ADDR_W-1:0] A_HI = A_CMP0 + ADDR_W'(2 * g);
    localparam logic [ADDR_W-1:0] A_LO = A_CMP0 + ADDR_W'(2 * g + 1);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufQ[g]  <= '1;
        holdQ[g] <= 1'b0;
      end else if (wrEn && addr == A_HI) begin
        bufQ[g][TMR_W-1:BYTE_W] <= wrData;
        holdQ[g]                <= 1'b1;
      end else if (wrEn && addr == A_LO) begin
        bufQ[g][BYTE_W-1:0] <= wrData;
        holdQ[g]            <= 1'b0;
      end
    end
  end

  // status flags: event set beats write-one-to-clear
  always_comb begin
    setVec = {evt.cmpMatch, evt.periodEnd};
    clrVec = (wrEn && addr == A_STAT) ? wrData[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (flagsQ & ~clrVec) | setVec;
  end

  always_comb begin
    irq = ~irqMask & ((flagsQ[0] & ctrlQ[CB_CAPIE]) |
                      ((|flagsQ[NFLAG-1:1]) & ctrlQ[CB_CMPIE]));
  end

  // strobes to the datapath; one-pulse bit has no effect while PWM is set
  always_comb begin
    ctl.pwmMode = ctrlQ[CB_PWM];
    ctl.lvl1    = ctrlQ[CB_LVL1];
    ctl.lvl2    = ctrlQ[CB_LVL2];
    ctl.clkSel  = clkSel_e'(ctrlQ[CB_CLK +: 2]);
    ctl.cmpBuf  = bufQ;
    ctl.cmpHold = holdQ;
  end

  always_comb begin
    case (addr)
      A_CTRL:   rdData = ctrlQ;
      A_STAT:   rdData = {{(BYTE_W-NFLAG){1'b0}}, flagsQ};
      3'd2:     rdData = bufQ[0][TMR_W-1:BYTE_W];
      3'd3:     rdData = bufQ[0][BYTE_W-1:0];
      3'd4:     rdData = bufQ[1][TMR_W-1:BYTE_W];
      3'd5:     rdData = bufQ[1][BYTE_W-1:0];
      A_CNT_HI: rdData = cntVal[TMR_W-1:BYTE_W];
      A_CNT_LO: rdData = cntVal[BYTE_W-1:0];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic             extClkIn,
  output evt_t             evt,
  output logic [TMR_W-1:0] cntQ,
  output logic             pwmOut
);
  logic [SYNC_N-1:0]          syncQ;
  logic                       extPrevQ;
  logic                       extRise;
  logic [DIV_W-1:0]           psQ;
  logic [DIV_W-1:0]           divHit;
  logic                       tick;
  logic                       pwmPrevQ;
  logic                       pwmStart;
  logic [NCMP-1:0][TMR_W-1:0] actQ;
  logic [NCMP-1:0]            hit;
  logic                       periodEnd;

  // external clock resynchroniser and edge detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      extPrevQ <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_N-2:0], extClkIn};
      extPrevQ <= syncQ[SYNC_N-1];
    end
  end
  assign extRise = syncQ[SYNC_N-1] & ~extPrevQ;

  // prescaler: divide by 2^(k+1) when the low k+1 bits are all ones
  always_ff @(posedge clk) begin
    if (!rstN) psQ <= '0;
    else       psQ <= psQ + DIV_W'(1);
  end

  for (genvar k = 0; k < DIV_W; k++) begin : g_div
    assign divHit[k] = &psQ[k:0];
  end

  always_comb begin
    case (ctl.clkSel)
      CLK_DIV2: tick = divHit[0];
      CLK_DIV4: tick = divHit[1];
      CLK_DIV8: tick = divHit[2];
      default:  tick = extRise;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pwmPrevQ <= 1'b0;
    else       pwmPrevQ <= ctl.pwmMode;
  end
  assign pwmStart = ctl.pwmMode & ~pwmPrevQ;

  // comparators and their active (shadowed) values
  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    assign hit[c] = tick & (cntQ == actQ[c]) & ~ctl.cmpHold[c];
    always_ff @(posedge clk) begin
      if (!rstN) actQ[c] <= '1;
      else if (!ctl.pwmMode || pwmStart || periodEnd) actQ[c] <= ctl.cmpBuf[c];
    end
    assign evt.cmpMatch[c] = hit[c] & ~ctl.pwmMode;
  end

  assign periodEnd     = ctl.pwmMode & ~pwmStart & hit[1];
  assign evt.periodEnd = periodEnd;

  always_ff @(posedge clk) begin
    if (!rstN)          cntQ <= RELOAD_VAL;
    else if (pwmStart)  cntQ <= RELOAD_VAL;
    else if (tick)      cntQ <= periodEnd ? RELOAD_VAL : cntQ + TMR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              pwmOut <= 1'b0;
    else if (!ctl.pwmMode)  pwmOut <= 1'b0;
    else if (pwmStart)      pwmOut <= pwmOut;
    else if (hit[1])        pwmOut <= ctl.lvl2;
    else if (hit[0])        pwmOut <= ctl.lvl1;
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              extClkIn,
  input  logic              irqMask,
  output logic              irq,
  output logic              pwmOut
);
  ctlStrobe_t       ctl;
  evt_t             evt;
  logic [TMR_W-1:0] cntVal;
  logic [NFLAG-1:0] flagsQ;

  pwm_timer_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .irqMask(irqMask),
    .evt    (evt),
    .cntVal (cntVal),
    .ctl    (ctl),
    .rdData (rdData),
    .flagsQ (flagsQ),
    .irq    (irq)
  );

  pwm_timer_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .extClkIn(extClkIn),
    .evt     (evt),
    .cntQ    (cntVal),
    .pwmOut  (pwmOut)
  );
endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker
  import pwm_timer_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input ctlStrobe_t       ctl,
  input evt_t             evt,
  input logic [TMR_W-1:0] cntVal,
  input logic [NFLAG-1:0] flagsQ,
  input logic             irqMask,
  input logic             irq,
  input logic             pwmOut
);
  a_r2_reload: assert property (@(posedge clk) disable iff (!rstN)
    evt.periodEnd |=> cntVal == RELOAD_VAL);

  a_r1_period_level: assert property (@(posedge clk) disable iff (!rstN)
    evt.periodEnd |=> pwmOut == $past(ctl.lvl2));

  a_r4_equal_levels: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pwmMode && ctl.lvl1 == ctl.lvl2 && pwmOut == ctl.lvl1) |=> pwmOut == $past(ctl.lvl1));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    evt.periodEnd |=> flagsQ[0]);

  a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    irqMask |-> !irq);

  a_r6_no_cmp_flags: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pwmMode && flagsQ[2:1] == 2'b00) |=> flagsQ[2:1] == 2'b00);

  a_r7_hold_period: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cmpHold[1] |-> !evt.periodEnd);

  a_r1_off_low: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.pwmMode |=> !pwmOut);
endmodule

bind pwm_timer pwm_timer_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .ctl    (ctl),
  .evt    (evt),
  .cntVal (cntVal),
  .flagsQ (flagsQ),
  .irqMask(irqMask),
  .irq    (irq),
  .pwmOut (pwmOut)
);

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       extClkIn = 1'b0;
  logic       irqMask = 1'b0;
  logic       irq;
  logic       pwmOut;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  typedef struct { bit lvl; int len; string req; } seg_t;
  seg_t expQ[$];

  always #5 clk = ~clk;

  pwm_timer u_pwm_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .extClkIn(extClkIn), .irqMask(irqMask), .irq(irq),
    .pwmOut(pwmOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b0; addr = a;
    #1 d = rdData;
  endtask

  task automatic push(input bit lvl, input int len, input string req);
    seg_t s;
    s.lvl = lvl; s.len = len; s.req = req;
    expQ.push_back(s);
  endtask

  task automatic waitRise();
    do @(negedge clk); while (pwmOut !== 1'b0);
    do @(negedge clk); while (pwmOut !== 1'b1);
    #1;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic extPulse();
    @(negedge clk); extClkIn = 1'b1;
    repeat (4) @(negedge clk);
    extClkIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: measures each output segment in cycles and compares it with the queue
  int  cyc = 0;
  int  lastCh = 0;
  bit  prevOut = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (pwmOut !== prevOut) begin
      if (expQ.size() != 0) begin
        seg_t s;
        s = expQ.pop_front();
        check({s.req, " segment level"}, int'(prevOut), int'(s.lvl));
        check({s.req, " segment length"}, cyc - lastCh, s.len);
      end
      lastCh = cyc;
      prevOut = pwmOut;
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    logic [7:0] d, d2;
    int hi;
    bit sawLow;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 / R11 reset state through the register map
    rd(3'd1, d);  check("R10 status after reset", d, 8'h00);
    rd(3'd0, d);  check("R10 control after reset", d, 8'h00);
    check("R10 pwmOut after reset", pwmOut, 0);
    check("R10 irq after reset", irq, 0);
    rd(3'd2, d);  check("R11 edge compare high reset", d, 8'hFF);
    rd(3'd3, d);  check("R11 edge compare low reset", d, 8'hFF);
    rd(3'd5, d);  check("R10 period compare low reset", d, 8'hFF);

    // R6: outside PWM both comparators at 0xFFFF match soon after reset
    repeat (20) @(negedge clk);
    rd(3'd1, d);  check("R6 compare flags outside PWM", d, 8'h06);
    wr(3'd1, 8'h07);
    rd(3'd1, d);  check("R5 write-one clears flags", d, 8'h00);

    // R1 / R2: edge=2, period=6, edge level 0, period level 1, div2
    wr(3'd2, 8'h00); wr(3'd3, 8'h02);
    wr(3'd4, 8'h00); wr(3'd5, 8'h06);
    wr(3'd0, 8'h49);
    waitRise();
    push(1, 14, "R1"); push(0, 8, "R1"); push(1, 14, "R2"); push(0, 8, "R2");
    drain();

    // R3: new edge value written mid-period applies from the next period
    waitRise();
    wr(3'd2, 8'h00); wr(3'd3, 8'h04);
    push(1, 14, "R3"); push(0, 8, "R3"); push(1, 18, "R3"); push(0, 4, "R3");
    drain();

    // R5 / R6: capture flag set, compare flags quiet, irq and mask
    waitRise();
    rd(3'd1, d);  check("R6 status in PWM (capture only)", d, 8'h01);
    check("R5 irq with capture flag", irq, 1);
    irqMask = 1'b1; #1;
    check("R5 irq masked", irq, 0);
    irqMask = 1'b0;

    // R5: clear writes held across a period end; set wins for one cycle
    waitRise();
    hi = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (i > 0 && irq === 1'b1) hi++;
      wrEn = 1'b1; addr = 3'd1; wrData = 8'h01;
    end
    @(negedge clk); wrEn = 1'b0;
    check("R5 set beats clear, irq cycles", hi, 1);

    // R8: divide by 4 and by 8 with edge=2 again
    wr(3'd2, 8'h00); wr(3'd3, 8'h02);
    wr(3'd0, 8'h59);
    waitRise(); waitRise();
    push(1, 28, "R8 div4"); push(0, 16, "R8 div4");
    drain();
    wr(3'd0, 8'h69);
    waitRise(); waitRise();
    push(1, 56, "R8 div8"); push(0, 32, "R8 div8");
    drain();

    // R9: one-pulse bit together with PWM, div2
    wr(3'd0, 8'h4B);
    waitRise(); waitRise();
    push(1, 14, "R9"); push(0, 8, "R9");
    drain();

    // R7: high byte alone holds the edge comparator
    waitRise();
    wr(3'd2, 8'h00);
    hi = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwmOut !== 1'b1) hi++;
    end
    check("R7 output held at period level while held", hi, 0);
    wr(3'd3, 8'h02);
    waitRise(); waitRise();
    push(1, 14, "R7 released"); push(0, 8, "R7 released");
    drain();

    // R4: equal levels give a constant output
    wr(3'd0, 8'h4D);
    repeat (30) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwmOut !== 1'b1) hi++;
    end
    check("R4 constant output", hi, 0);

    // R2 / R8: external clock, counter reload observed on the counter port
    wr(3'd0, 8'h79);
    sawLow = 0;
    for (int i = 0; i < 40; i++) begin
      extPulse();
      if (pwmOut === 1'b0) sawLow = 1;
      if (sawLow && pwmOut === 1'b1) break;
    end
    check("R2 period end reached on external clock", pwmOut, 1);
    rd(3'd6, d); rd(3'd7, d2);
    check("R2 counter after reload", {d, d2}, 16'hFFFC);
    repeat (10) @(negedge clk);
    rd(3'd7, d2);
    check("R8 external clock idle holds count", d2, 8'hFC);
    extPulse();
    rd(3'd6, d); rd(3'd7, d2);
    check("R8 one tick per external edge", {d, d2}, 16'hFFFD);

    finish();
  end
endmodule